// File: doc/BRIEF.md
# LED grid multiplexer with dimming

This block scans a multiplexed LED display. Time is split into slots of a fixed number of oscillator ticks. Each display slot lights one grid line. While the grid is lit, the segment lines carry the two display-memory bytes that belong to that grid. Brightness comes from a 3-bit code that selects how many sixteenths of the slot the grid and its segments stay lit. A short dark gap opens every slot, so two grids can never overlap in time.

Two layouts can be chosen. In the first there are six grids of twelve segments. In the second there are seven grids of eleven segments. One output pin is shared: it carries segment 12 in the six-grid layout and grid 7 in the seven-grid layout.

After the display slots of a frame, the block runs five key-source slots. In these slots all grids are dark and one of the first ten segment lines is raised, so that a key matrix can be read. The first five sources are used in even frames and the last five in odd frames, so one full key scan takes two frames. A one-clock pulse marks the end of each two-frame cycle, which is the point where a key scanner would latch its inputs.

Top module: `grid_mux`

## Requirements
- R1: While disp_ctl[3] is 0, every grid, segment, shared and key-source output is 0 and cycle_end stays 0. On enable, all counters restart from grid 1, tick 0, even frame; only ticks sampled after the first clock edge that sees disp_ctl[3]=1 are counted.
- R2: A slot lasts 18 ticks: 2 blank ticks followed by 16 drive ticks. Each frame runs grid 1, 2, ... in turn, then the key slots. The six-grid layout (grid7_mode=0) has 6 grid slots; the seven-grid layout (grid7_mode=1) has 7. grid_en[k] is grid k+1, and at most one grid is lit at a time.
- R3: When grid g (counted from 0) is lit, seg_en[7:0] equals byte 2g of the display memory and seg_en[10:8] equals bits 2:0 of byte 2g+1.
- R4: In the six-grid layout, shared_en is segment 12 and follows bit 3 of byte 2g+1 while grid g is lit. In the seven-grid layout, shared_en is grid 7 and bit 3 of byte 13 has no effect.
- R5: disp_ctl[2:0] selects the lit time in ticks, counted from the first drive tick: codes 0..7 give 1, 2, 4, 10, 11, 12, 13 and 14 ticks.
- R6: During the two blank ticks of any slot, every grid, segment, shared and key-source output is 0.
- R7: Key slot j (0..4) drives key_src bit j in even frames and bit 5+j in odd frames, for all 16 drive ticks whatever the dim code. In that slot seg_en[9:0] mirrors key_src, while seg_en[10], the grids and shared_en are 0.
- R8: cycle_end is a single-clock pulse. It appears in the cycle after the tick that ends the last key slot of an odd frame, so consecutive pulses are 2 x 18 x (grids + 5) ticks apart.
- R9: The memory read port returns ram_rdata one clock after ram_addr. The block fetches addresses 2g and 2g+1 at the start of each slot, which requires ticks to be at least 2 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock scan-rate enable from the oscillator divider |
| grid7_mode | input | 1 | 0: six grids x twelve segments, 1: seven grids x eleven segments |
| disp_ctl | input | 4 | Bit 3 display on, bits 2:0 dim code |
| ram_addr | output | 4 | Display memory read address |
| ram_rdata | input | 8 | Display memory read data, one clock latency |
| grid_en | output | 6 | Grid 1..6 enables |
| seg_en | output | 11 | Segment 1..11 enables (segments 1..10 also key sources) |
| shared_en | output | 1 | Segment 12 or grid 7, depending on layout |
| key_src | output | 10 | Key-source strobes |
| cycle_end | output | 1 | End of a two-frame scan cycle |

## Verification
A slot or phase counter that has slipped moves the grid, or the blank gap, onto the wrong tick. The per-cycle comparison then reports it within one tick. A broken fetch shows up as wrong segment bits during the first lit tick of the affected grid. A wrong frame bit shows up at the first key slot after the slip, as the wrong half of the key sources. Errors in the cycle length or frame parity show up as a wrong tick spacing between two cycle_end pulses, which is visible within one full two-frame cycle.

// File: rtl/grid_mux.sv
`timescale 1ns/1ps
module grid_mux #(
  parameter int BLANK_TICKS = 2,
  parameter int KEY_SRC     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               grid7_mode,
  input  logic [3:0]         disp_ctl,
  output logic [3:0]         ram_addr,
  input  logic [7:0]         ram_rdata,
  output logic [5:0]         grid_en,
  output logic [10:0]        seg_en,
  output logic               shared_en,
  output logic [KEY_SRC-1:0] key_src,
  output logic               cycle_end
);
  localparam int DRIVE     = 16;
  localparam int SLOT      = BLANK_TICKS + DRIVE;
  localparam int PH_W      = $clog2(SLOT);
  localparam int KEY_SLOTS = KEY_SRC / 2;
  localparam int SL_W      = $clog2(7 + KEY_SLOTS);

  logic            run, frame;
  logic [PH_W-1:0] ph;
  logic [SL_W-1:0] slot;
  logic [1:0]      fstep;
  logic [7:0]      pat_lo;
  logic [3:0]      pat_hi;

  function automatic logic [4:0] on_ticks(input logic [2:0] c);
    case (c)
      3'd0: on_ticks = 5'd1;
      3'd1: on_ticks = 5'd2;
      3'd2: on_ticks = 5'd4;
      3'd3: on_ticks = 5'd10;
      3'd4: on_ticks = 5'd11;
      3'd5: on_ticks = 5'd12;
      3'd6: on_ticks = 5'd13;
      default: on_ticks = 5'd14;
    endcase
  endfunction

  wire             on        = disp_ctl[3];
  wire [2:0]       ngrid     = grid7_mode ? 3'd7 : 3'd6;
  wire [SL_W-1:0]  last_slot = SL_W'(ngrid) + SL_W'(KEY_SLOTS - 1);
  wire             ph_last   = (ph == PH_W'(SLOT - 1));
  wire             slot_last = (slot >= last_slot);
  wire             adv       = run && tick;
  wire             wrap      = adv && ph_last;
  wire             unused_hi = ^ram_rdata[7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; frame <= 1'b0; ph <= '0; slot <= '0; fstep <= 2'd0;
      pat_lo <= '0; pat_hi <= '0; cycle_end <= 1'b0;
    end else begin
      run       <= on;
      cycle_end <= on && wrap && slot_last && frame;
      if (!on) begin
        frame <= 1'b0; ph <= '0; slot <= '0; fstep <= 2'd0;
      end else begin
        if (adv) ph <= ph_last ? '0 : ph + 1'b1;
        if (wrap) begin
          slot <= slot_last ? '0 : slot + 1'b1;
          if (slot_last) frame <= ~frame;
        end
        if (!run || wrap) fstep <= 2'd1;
        else if (fstep != 2'd0) fstep <= fstep + 2'd1;
        if (fstep == 2'd2) pat_lo <= ram_rdata;
        if (fstep == 2'd3) pat_hi <= ram_rdata[3:0];
      end
    end
  end

  assign ram_addr = {slot[2:0], fstep == 2'd2};

  wire [PH_W-1:0] dt      = ph - PH_W'(BLANK_TICKS);
  wire            drive   = on && (ph >= PH_W'(BLANK_TICKS));
  wire            is_grid = slot < SL_W'(ngrid);
  wire            lit     = drive && is_grid && (32'(dt) < 32'(on_ticks(disp_ctl[2:0])));
  wire            ks      = drive && !is_grid;
  wire [SL_W-1:0] kbit    = (slot - SL_W'(ngrid)) + (frame ? SL_W'(KEY_SLOTS) : '0);
  wire [6:0]      gv      = lit ? (7'd1 << slot[2:0]) : 7'd0;

  assign grid_en   = gv[5:0];
  assign shared_en = grid7_mode ? gv[6] : (lit && pat_hi[3]);
  assign key_src   = ks ? (KEY_SRC'(1) << kbit) : '0;
  assign seg_en    = lit ? {pat_hi[2:0], pat_lo} : (ks ? 11'(key_src) : 11'd0);

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> (grid_en == 6'd0 && seg_en == 11'd0 && !shared_en && key_src == '0));
  // R2
  one_grid_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gv));
  // R6
  blank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv != 7'd0) |=> (gv == 7'd0 || gv == $past(gv)));
  // R7
  key_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_src != '0) |-> ($onehot(key_src) && gv == 7'd0 && !shared_en));
  // R4
  shared_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grid7_mode && shared_en) |-> grid_en == 6'd0);
  // R8
  cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !cycle_end);
endmodule

// File: tb/sim_grid_mux.sv
`timescale 1ns/1ps
module sim_grid_mux;
  localparam int CLK_NS = 10;
  localparam int BL     = 2;
  localparam int SLOT   = 18;
  localparam int KS     = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, grid7_mode = 1'b0;
  logic [3:0] disp_ctl = 4'd0;
  logic [3:0] ram_addr;
  logic [7:0] ram_rdata = 8'd0;
  logic [5:0] grid_en;
  logic [10:0] seg_en;
  logic shared_en, cycle_end;
  logic [9:0] key_src;
  logic [7:0] mem [16];
  bit fixed_gap = 1'b0, chk_en = 1'b0;
  int checks = 0, errors = 0;

  grid_mux u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .grid7_mode(grid7_mode),
    .disp_ctl(disp_ctl), .ram_addr(ram_addr), .ram_rdata(ram_rdata), .grid_en(grid_en),
    .seg_en(seg_en), .shared_en(shared_en), .key_src(key_src), .cycle_end(cycle_end));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) ram_rdata <= mem[ram_addr];

  function automatic int ontime(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 10;
      3'd4: return 11; 3'd5: return 12; 3'd6: return 13; default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      int gap;
      gap = fixed_gap ? 3 : 2 + $urandom_range(0, 2);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  end

  bit m_run = 0, m_ce = 0;
  int m_ph = 0, m_slot = 0, m_frame = 0;
  always @(posedge clk) begin
    int ns;
    ns = (grid7_mode ? 7 : 6) + KS;
    if (!rst_n) begin
      m_run <= 0; m_ce <= 0; m_ph <= 0; m_slot <= 0; m_frame <= 0;
    end else begin
      m_ce  <= disp_ctl[3] && m_run && tick && m_ph == SLOT-1 && m_slot == ns-1 && m_frame == 1;
      m_run <= disp_ctl[3];
      if (!disp_ctl[3]) begin
        m_ph <= 0; m_slot <= 0; m_frame <= 0;
      end else if (m_run && tick) begin
        if (m_ph == SLOT-1) begin
          m_ph <= 0;
          if (m_slot == ns-1) begin m_slot <= 0; m_frame <= 1 - m_frame; end
          else m_slot <= m_slot + 1;
        end else m_ph <= m_ph + 1;
      end
    end
  end

  int tcnt = 0;
  bit have_ce = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n && chk_en) begin
      logic [6:0] eg; logic [10:0] es; logic [9:0] ek; logic esh;
      logic [7:0] lo, hi;
      int ng, dt;
      string tg, tb_tag;
      ng = grid7_mode ? 7 : 6;
      dt = m_ph - BL;
      eg = '0; es = '0; ek = '0; esh = 1'b0;
      if (disp_ctl[3] && m_ph >= BL) begin
        if (m_slot < ng) begin
          if (dt < ontime(disp_ctl[2:0])) begin
            eg[m_slot] = 1'b1;
            lo = mem[2*m_slot]; hi = mem[2*m_slot+1];
            es = {hi[2:0], lo};
            esh = grid7_mode ? eg[6] : hi[3];
          end
        end else begin
          ek[m_slot - ng + KS*m_frame] = 1'b1;
          es = {1'b0, ek};
        end
      end
      tg = !disp_ctl[3] ? "R1" : (m_ph < BL ? "R6" : "");
      tb_tag = (tg != "") ? tg : "R2 R5";
      chk(grid_en == eg[5:0], tb_tag, grid_en, eg[5:0]);
      // R9: fetched bytes appear as segments
      tb_tag = (tg != "") ? tg : "R3 R9";
      chk(seg_en == es, tb_tag, seg_en, es);
      tb_tag = (tg != "") ? tg : "R4";
      chk(shared_en == esh, tb_tag, shared_en, esh);
      tb_tag = (tg != "") ? tg : "R7";
      chk(key_src == ek, tb_tag, key_src, ek);
      chk(cycle_end == m_ce, "R8", cycle_end, m_ce);
      if (!disp_ctl[3]) begin
        tcnt = 0; have_ce = 0;
      end else begin
        if (tick) tcnt++;
        if (cycle_end) begin
          if (have_ce) chk(tcnt == 2*SLOT*(ng+KS), "R8 spacing", tcnt, 2*SLOT*(ng+KS));
          tcnt = 0; have_ce = 1;
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog: actual=0 expected=1");
    summary();
  end

  task automatic dim_probe(input bit m, input logic [2:0] c);
    int n;
    disp_ctl = 4'd0; fixed_gap = 1'b1; grid7_mode = m;
    repeat (6) @(negedge clk);
    disp_ctl = {1'b1, c};
    while (!grid_en[0]) @(negedge clk);
    n = 0;
    while (grid_en[0]) begin n++; @(negedge clk); end
    // R5: lit time per dim code
    chk(n == 3*ontime(c), "R5 lit time", n, 3*ontime(c));
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(grid_en == 0 && seg_en == 0 && !shared_en && key_src == 0 && !cycle_end,
        "R1 reset", {grid_en, seg_en}, 0);
    rst_n = 1'b1; chk_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(grid_en == 0 && seg_en == 0 && key_src == 0, "R1 off", {grid_en, seg_en}, 0);
    for (int i = 0; i < 14; i++) mem[i] = 8'h5A ^ 8'(i * 37);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 8; c++) dim_probe(m[0], c[2:0]);
    for (int e = 0; e < 6; e++) begin
      int pulses;
      disp_ctl = 4'd0; fixed_gap = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 14; i++)
        mem[i] = (e == 0) ? 8'hFF : (e == 1) ? 8'h00 : 8'($urandom);
      grid7_mode = (e < 2) ? e[0] : 1'($urandom);
      disp_ctl = {1'b1, (e == 0) ? 3'd7 : (e == 1) ? 3'd0 : 3'($urandom)};
      pulses = 0;
      while (pulses < 3) begin
        @(negedge clk);
        if (cycle_end) pulses++;
        if ($urandom_range(0, 399) == 0) disp_ctl[2:0] = 3'($urandom);
      end
    end
    disp_ctl = 4'd0;
    repeat (3) @(negedge clk);
    chk(grid_en == 0 && seg_en == 0 && key_src == 0 && !shared_en, "R1 final off",
        {grid_en, seg_en}, 0);
    summary();
  end
endmodule